// File: doc/BRIEF.md
# Read-After-Write Stall Detector

This block watches the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no operand forwarding. It compares the decode instruction's source register indices with the destinations of the instructions currently in the execute and memory stages. When any source is still being produced, it raises one hazard flag. That flag freezes the program counter and the fetch/decode pipeline register, and it selects all-zero control bits for the execute stage so that a bubble enters the pipe.

The decision is purely combinational and is taken again in every cycle. A dependent instruction therefore waits exactly as long as its nearest producer needs to reach writeback: two cycles when the producer is one instruction ahead and one cycle when it is two ahead. A producer in writeback never causes a stall, because the register file writes in the first half of the cycle and reads in the second. Several producers can match at the same time, and the flag then stays high until the nearest one has cleared.

The block decodes the opcode to learn which index fields act as sources. The fields sit at fixed bit positions in every instruction word, so they can be extracted before the format is known.

Top module: `raw_stall_detector`

## Requirements
- R1: The hazard flag is high when the execute or memory stage has its write enable set, its destination index is nonzero, and that index equals the decode instruction's rs field (bits 25:21). This applies to every opcode except jump (opcode 6'h02), which reads no register.
- R2: The rt field (bits 20:16) is compared only when the opcode (bits 31:26) is 6'h00 (register-register), 6'h2B (store), 6'h04 or 6'h05 (branch compare). For load (6'h23), immediate arithmetic such as 6'h08, and jump (6'h02), an rt match raises no hazard.
- R3: A stage whose destination index is zero never causes a hazard.
- R4: A stage whose write enable is low never causes a hazard, whatever its destination index.
- R5: While the flag is high, the PC write enable and the fetch/decode write enable are low and the execute bubble select is high. While the flag is low, the two write enables are high and the bubble select is low.
- R6: In a pipeline built around the block, where a producer's destination moves from execute to memory to writeback once per cycle, a consumer is stalled for exactly 2 cycles when its producer is directly ahead of it. It is stalled for exactly 1 cycle when one unrelated instruction lies between them, and for 0 cycles when two or more lie between them. A store that reads a loaded register right after the load stalls for 2 cycles.
- R7: When the execute and memory stages both hold matching producers, the flag stays high until the execute-stage producer has left memory. This gives 2 stall cycles in total for back-to-back writers of the same register.
- R8: With both stage write enables cleared, as they are after reset, no stall is raised for any decode instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the embedded checks |
| rstN | input | 1 | Active-low reset; disables the embedded checks |
| idInstr | input | 32 | Instruction word held in the decode stage |
| exDest | input | 5 | Destination index held in the execute-stage pipeline register |
| exWrEn | input | 1 | Register write enable of the execute-stage instruction |
| memDest | input | 5 | Destination index held in the memory-stage pipeline register |
| memWrEn | input | 1 | Register write enable of the memory-stage instruction |
| hazardFlag | output | 1 | High while the decode instruction must wait |
| pcWrEn | output | 1 | Program counter update enable |
| ifIdWrEn | output | 1 | Fetch/decode pipeline register load enable |
| exBubbleSel | output | 1 | Selects zeroed control bits into the execute stage |

## Verification
Several properties are checked on every clock edge:
- an idle stage (write enable low or destination zero) never reports a match;
- a live stage whose destination equals an active source always reports one;
- load and jump never mark rt as a source;
- the three stall outputs always agree with the flag.

The exact stall lengths depend on how destinations travel through the surrounding pipeline registers, which the block cannot see. So the 2/1/0-cycle rule, the overlapping-producer case and the quiet start after reset are shown only by the bench. It runs short instruction sequences through a behavioural pipeline model and totals the bubbles.

// File: rtl/raw_stall_pkg.sv
package raw_stall_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int OPC_W   = 6;
  localparam int OPC_LSB = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int NUM_PROD = 2;  // execute and memory stages

  localparam logic [OPC_W-1:0] OP_REGREG = 6'h00;
  localparam logic [OPC_W-1:0] OP_JUMP   = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ    = 6'h04;
  localparam logic [OPC_W-1:0] OP_BNE    = 6'h05;
  localparam logic [OPC_W-1:0] OP_LOAD   = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE  = 6'h2B;

  // strobes from control to datapath: which index fields are live sources
  typedef struct packed {
    logic rsIsSource;
    logic rtIsSource;
  } srcUse_t;
endpackage

// File: rtl/raw_src_compare.sv
module raw_src_compare
  import raw_stall_pkg::*;
#(
  parameter int N_STAGE = NUM_PROD,
  parameter int IW      = IDX_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [IW-1:0]             rsIdx,
  input  logic [IW-1:0]             rtIdx,
  input  srcUse_t                   srcUse,
  input  logic [N_STAGE-1:0][IW-1:0] prodDest,
  input  logic [N_STAGE-1:0]        prodWe,
  output logic [N_STAGE-1:0]        hitVec
);
  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    logic liveProd;
    logic rsHit;
    logic rtHit;

    assign liveProd = prodWe[g] && (prodDest[g] != '0);
    assign rsHit    = srcUse.rsIsSource && (prodDest[g] == rsIdx);
    assign rtHit    = srcUse.rtIsSource && (prodDest[g] == rtIdx);
    assign hitVec[g] = liveProd && (rsHit || rtHit);

    // R3 / R4: an idle or zero-destination stage never matches
    p_idle_stage_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!prodWe[g] || prodDest[g] == '0) |-> !hitVec[g]);

    // R1: a live producer that matches an active rs must be reported
    p_rs_match_r1: assert property (@(posedge clk) disable iff (!rstN)
      (prodWe[g] && prodDest[g] != '0 && prodDest[g] == rsIdx && srcUse.rsIsSource)
        |-> hitVec[g]);
  end
endmodule

// File: rtl/raw_stall_ctrl.sv
module raw_stall_ctrl
  import raw_stall_pkg::*;
#(
  parameter int N_STAGE = NUM_PROD
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [N_STAGE-1:0] hitVec,
  output srcUse_t            srcUse,
  output logic               hazardFlag,
  output logic               pcWrEn,
  output logic               ifIdWrEn,
  output logic               exBubbleSel
);
  always_comb begin
    srcUse = '{rsIsSource: 1'b1, rtIsSource: 1'b0};
    case (opcode)
      OP_REGREG, OP_STORE, OP_BEQ, OP_BNE: srcUse.rtIsSource = 1'b1;
      OP_JUMP:                            srcUse.rsIsSource = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    hazardFlag  = |hitVec;
    pcWrEn      = !hazardFlag;
    ifIdWrEn    = !hazardFlag;
    exBubbleSel = hazardFlag;
  end

  // R2: load and jump never treat rt as a source
  p_rt_unused_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opcode == OP_LOAD || opcode == OP_JUMP) |-> !srcUse.rtIsSource);

  // R5: a match anywhere freezes fetch and injects a bubble
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |-> (!pcWrEn && !ifIdWrEn && exBubbleSel));

  // R5: no match lets the front of the pipe advance
  p_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec == '0) |-> (pcWrEn && ifIdWrEn && !exBubbleSel && !hazardFlag));
endmodule

// File: rtl/raw_stall_detector.sv
module raw_stall_detector
  import raw_stall_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] idInstr,
  input  logic [IDX_W-1:0]   exDest,
  input  logic               exWrEn,
  input  logic [IDX_W-1:0]   memDest,
  input  logic               memWrEn,
  output logic               hazardFlag,
  output logic               pcWrEn,
  output logic               ifIdWrEn,
  output logic               exBubbleSel
);
  srcUse_t                         srcUse;
  logic [NUM_PROD-1:0][IDX_W-1:0]  prodDest;
  logic [NUM_PROD-1:0]             prodWe;
  logic [NUM_PROD-1:0]             hitVec;
  logic                            unusedLowBits;

  assign prodDest      = {memDest, exDest};
  assign prodWe        = {memWrEn, exWrEn};
  assign unusedLowBits = ^idInstr[RT_LSB-1:0];

  raw_src_compare #(.N_STAGE(NUM_PROD), .IW(IDX_W)) i_cmp (
    .clk      (clk),
    .rstN     (rstN),
    .rsIdx    (idInstr[RS_LSB +: IDX_W]),
    .rtIdx    (idInstr[RT_LSB +: IDX_W]),
    .srcUse   (srcUse),
    .prodDest (prodDest),
    .prodWe   (prodWe),
    .hitVec   (hitVec)
  );

  raw_stall_ctrl #(.N_STAGE(NUM_PROD)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opcode      (idInstr[OPC_LSB +: OPC_W]),
    .hitVec      (hitVec),
    .srcUse      (srcUse),
    .hazardFlag  (hazardFlag),
    .pcWrEn      (pcWrEn),
    .ifIdWrEn    (ifIdWrEn),
    .exBubbleSel (exBubbleSel)
  );
endmodule

// File: tb/test_raw_stall_detector.sv
module test_raw_stall_detector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] idInstr = '0;
  logic [4:0]  exDest = '0;
  logic        exWrEn = 1'b0;
  logic [4:0]  memDest = '0;
  logic        memWrEn = 1'b0;
  logic        hazardFlag, pcWrEn, ifIdWrEn, exBubbleSel;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raw_stall_detector i_raw_stall_detector (
    .clk(clk), .rstN(rstN), .idInstr(idInstr),
    .exDest(exDest), .exWrEn(exWrEn), .memDest(memDest), .memWrEn(memWrEn),
    .hazardFlag(hazardFlag), .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn),
    .exBubbleSel(exBubbleSel)
  );

  // instruction builders: opcode 31:26, rs 25:21, rt 20:16, rd 15:11
  function automatic logic [31:0] rr(int s, int t, int d);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] imm(logic [5:0] op, int s, int t);
    return {op, 5'(s), 5'(t), 16'd4};
  endfunction

  // reference: which fields are sources, which stages are live
  function automatic bit refHazard(logic [31:0] ins, logic [4:0] eD, logic eW,
                                   logic [4:0] mD, logic mW);
    int op = int'(ins[31:26]);
    int s = int'(ins[25:21]);
    int t = int'(ins[20:16]);
    bit useS = (op != 2);
    bit useT = (op == 0) || (op == 'h2B) || (op == 4) || (op == 5);
    bit h = 0;
    if (eW && eD != 0 && ((useS && int'(eD) == s) || (useT && int'(eD) == t))) h = 1;
    if (mW && mD != 0 && ((useS && int'(mD) == s) || (useT && int'(mD) == t))) h = 1;
    return h;
  endfunction

  function automatic void destOf(logic [31:0] ins, output logic [4:0] d, output logic w);
    int op = int'(ins[31:26]);
    d = '0; w = 1'b0;
    if (op == 0) begin d = ins[15:11]; w = 1'b1; end
    else if (op == 'h23 || op == 'h08) begin d = ins[20:16]; w = 1'b1; end
  endfunction

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs(bit expHaz, string req);
    check(hazardFlag == expHaz, req, "hazardFlag", int'(hazardFlag), int'(expHaz));
    check(pcWrEn == !expHaz && ifIdWrEn == !expHaz && exBubbleSel == expHaz,
          "R5", "pcWrEn/ifIdWrEn/bubble",
          int'({pcWrEn, ifIdWrEn, exBubbleSel}), int'({!expHaz, !expHaz, expHaz}));
  endtask

  task automatic direct(logic [31:0] ins, logic [4:0] eD, logic eW,
                        logic [4:0] mD, logic mW, bit expHaz, string req);
    @(posedge clk); #1;
    idInstr = ins; exDest = eD; exWrEn = eW; memDest = mD; memWrEn = mW;
    @(negedge clk);
    check(expHaz == refHazard(ins, eD, eW, mD, mW), req, "model", 0, 0);
    checkOutputs(expHaz, req);
  endtask

  // behavioural pipeline around the detector; returns total stall cycles
  task automatic runProg(logic [31:0] prog[$], int expStalls, string req);
    logic [31:0] q[$] = prog;
    logic [31:0] dec;
    logic [4:0]  eD = '0, mD = '0, nD;
    logic        eW = 1'b0, mW = 1'b0, nW;
    int          stalls = 0;
    int          cycles = prog.size() + 8;
    dec = q.pop_front();
    for (int c = 0; c < cycles; c++) begin
      bit exp;
      @(posedge clk); #1;
      idInstr = dec; exDest = eD; exWrEn = eW; memDest = mD; memWrEn = mW;
      @(negedge clk);
      exp = refHazard(dec, eD, eW, mD, mW);
      if (c == 0) check(hazardFlag == 1'b0, "R8", "first cycle after reset", int'(hazardFlag), 0);
      check(hazardFlag == exp, req, "per-cycle hazard", int'(hazardFlag), int'(exp));
      if (hazardFlag) stalls++;
      mD = eD; mW = eW;
      if (hazardFlag) begin
        eW = 1'b0; eD = '0;
      end else begin
        destOf(dec, nD, nW);
        eD = nD; eW = nW;
        dec = (q.size() > 0) ? q.pop_front() : 32'h0;
      end
    end
    check(stalls == expStalls, req, "total stall cycles", stalls, expStalls);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] p[$];
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkOutputs(1'b0, "R8");
    rstN = 1'b1;

    direct(rr(3,4,5), 5'd3, 1'b1, 5'd0, 1'b0, 1'b1, "R1");
    direct(rr(1,2,5), 5'd0, 1'b0, 5'd1, 1'b1, 1'b1, "R1");
    direct(rr(6,4,5), 5'd0, 1'b0, 5'd4, 1'b1, 1'b1, "R2");
    direct(imm(6'h23,1,7), 5'd7, 1'b1, 5'd0, 1'b0, 1'b0, "R2");
    direct(imm(6'h2B,1,7), 5'd7, 1'b1, 5'd0, 1'b0, 1'b1, "R2");
    direct(imm(6'h04,1,7), 5'd0, 1'b0, 5'd7, 1'b1, 1'b1, "R2");
    direct(imm(6'h05,1,7), 5'd7, 1'b1, 5'd0, 1'b0, 1'b1, "R2");
    direct(imm(6'h08,1,7), 5'd7, 1'b1, 5'd7, 1'b1, 1'b0, "R2");
    direct({6'h02, 5'd3, 5'd7, 16'd0}, 5'd3, 1'b1, 5'd7, 1'b1, 1'b0, "R2");
    direct(rr(0,0,5), 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, "R3");
    direct(rr(3,4,5), 5'd3, 1'b0, 5'd4, 1'b0, 1'b0, "R4");
    direct(rr(3,4,5), 5'd3, 1'b1, 5'd4, 1'b1, 1'b1, "R7");
    direct(rr(3,4,5), 5'd9, 1'b1, 5'd10, 1'b1, 1'b0, "R1");

    p = {rr(1,2,3), rr(3,4,5)};               runProg(p, 2, "R6");
    p = {rr(1,2,3), rr(8,9,7), rr(4,3,5)};    runProg(p, 1, "R6");
    p = {rr(1,2,3), rr(8,9,7), rr(8,9,10), rr(3,4,5)}; runProg(p, 0, "R6");
    p = {imm(6'h23,1,6), imm(6'h2B,2,6)};     runProg(p, 2, "R6");
    p = {imm(6'h23,1,6), imm(6'h08,2,6)};     runProg(p, 0, "R2");
    p = {rr(1,2,3), rr(10,11,3), rr(3,4,5)};  runProg(p, 2, "R7");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule